// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold DMA Request

This block buffers one direction of an audio serial port: 16-bit samples enter on a producer stream and leave on a consumer stream. For playback, the register bus is the producer and the serial shifter is the consumer. For capture, the roles are swapped. The block is the same in both cases. Only the rule that raises the DMA request changes, and the `dir_rx` control pin selects it. The block reports its fill count and four level flags. It raises a DMA request from a programmable 6-bit threshold. It keeps six sticky event bits, each with its own interrupt enable, and a global enable gates the combined interrupt output.

Both data edges use valid/ready. On the producer side, `in_ready` is high while the block is enabled and either has room or is being popped in the same cycle. The producer is a strobe source that does not wait. A word offered while `in_ready` is low is therefore discarded and recorded as an overflow. On the consumer side, `out_valid` is high while a sample is held, and `out_ready` acts as a pop strobe. Asserting `out_ready` while `out_valid` is low records a starve event. The block clears held events through a write-to-clear mask strobe. Dropping `fifo_en` flushes the contents and silences the DMA request.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset the following hold: `fill_count` is 0, `flag_empty` is 1, `events` is 0, `pending` and `irq` are 0, `out_valid` is 0 and `out_data` is 0.
- R2: While enabled, accepted words leave in arrival order. `out_data[15:0]` is the oldest sample and `out_data[16]` is 1 while a sample is held. `out_data` is all zero while empty. `fill_count` tracks the number of held samples, from 0 to 32.
- R3: `flag_empty` is high when the count is 0 and `flag_aempty` when the count is at most 4. `flag_full` is high when the count is 32 and `flag_aful` when the count is at least 28.
- R4: A pop (`out_ready` high) while enabled and `out_valid` is low sets `events[4]` (starve) at the next clock edge. `out_data[16]` reads 0 in that cycle.
- R5: `in_valid` while enabled and `in_ready` is low sets `events[5]` (overflow) at the next edge. The word is discarded and neither the count nor the head sample changes.
- R6: With `dir_rx`=0, `dma_req` is high while enabled and the count is at most `dma_level`. With `dir_rx`=1, `dma_req` is high while enabled and the count is at least `dma_level`.
- R7: If the block holds at least one sample and a push and a pop happen in the same cycle, the count is unchanged and no overflow is recorded. When the block is full, `in_ready` is high in any cycle where `out_ready` is high.
- R8: While enabled, each level flag sets its sticky event bit at the next edge: empty sets bit 0, almost-empty bit 1, full bit 2 and almost-full bit 3. The bit stays set after the flag drops.
- R9: `pending` is the OR of `events & irq_enable`. `irq` is `pending` gated by `irq_global_en`.
- R10: A cycle with `clr_strobe` high clears the event bits selected by `clr_mask` at the next edge. If a bit's set condition is present in that same cycle, the set wins.
- R11: While `fifo_en` is low, `in_ready`, `out_valid` and `dma_req` are low and the producer and consumer strobes record nothing. The count is 0 from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Enable; low flushes the contents |
| dir_rx | input | 1 | DMA rule: 0 playback (low-water), 1 capture (high-water) |
| in_valid | input | 1 | Producer offers a sample |
| in_data | input | 16 | Producer sample |
| in_ready | output | 1 | Sample will be accepted this cycle |
| out_ready | input | 1 | Consumer pop strobe |
| out_valid | output | 1 | A sample is held |
| out_data | output | 17 | Bit 16 data-valid flag, bits 15:0 oldest sample |
| dma_level | input | 6 | DMA threshold |
| irq_enable | input | 6 | Per-event interrupt enables, same bit order as `events` |
| irq_global_en | input | 1 | Global interrupt enable |
| clr_strobe | input | 1 | Write-to-clear strike |
| clr_mask | input | 6 | Event bits to clear |
| fill_count | output | 6 | Held sample count |
| flag_empty | output | 1 | Count is 0 |
| flag_aempty | output | 1 | Count at most 4 |
| flag_full | output | 1 | Count is 32 |
| flag_aful | output | 1 | Count at least 28 |
| events | output | 6 | Sticky events: empty, almost-empty, full, almost-full, starve, overflow (bit 0 to 5) |
| pending | output | 1 | Any enabled event held |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Interrupt |

## Verification
A corrupted read or write pointer appears on `out_data` at the first pop after the fault, as a sample out of arrival order. A count that drifts from the true occupancy shows up at once on `fill_count` and the level flags. Within one further cycle it also shows up in the sticky level events and in `dma_req`. A lost or spurious starve or overflow event is visible in `events` one edge after the strobe, and then in `pending` and `irq`.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
  localparam int unsigned NUM_EV = 6;

  typedef enum int unsigned {
    EV_EMPTY  = 0,
    EV_AEMPTY = 1,
    EV_FULL   = 2,
    EV_AFULL  = 3,
    EV_STARVE = 4,
    EV_OVFL   = 5
  } ev_idx_e;

  typedef struct packed {
    logic empty;
    logic aempty;
    logic full;
    logic afull;
  } level_flags_t;
endpackage

// File: rtl/audfifo_store.sv
module audfifo_store #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/audfifo_levels.sv
module audfifo_levels
  import audfifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned AE_LVL    = 4,
  parameter int unsigned AF_LVL    = 28,
  parameter int unsigned LVL_W     = 6,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1),
  localparam int unsigned CMP_W    = ((CNT_W > LVL_W) ? CNT_W : LVL_W) + 1
) (
  input  logic [CNT_W-1:0] count,
  input  logic             enable,
  input  logic             dir_rx,
  input  logic [LVL_W-1:0] dma_level,
  output level_flags_t     flags,
  output logic             dma_req
);
  logic [CMP_W-1:0] cnt_x, lvl_x;
  logic             low_water, high_water;

  assign cnt_x = CMP_W'(count);
  assign lvl_x = CMP_W'(dma_level);

  always_comb begin
    flags.empty  = (cnt_x == '0);
    flags.aempty = (cnt_x <= CMP_W'(AE_LVL));
    flags.full   = (cnt_x == CMP_W'(DEPTH));
    flags.afull  = (cnt_x >= CMP_W'(AF_LVL));
  end

  assign low_water  = (cnt_x <= lvl_x);
  assign high_water = (cnt_x >= lvl_x);
  assign dma_req    = enable & (dir_rx ? high_water : low_water);
endmodule

// File: rtl/audfifo_events.sv
module audfifo_events
  import audfifo_pkg::*;
#(
  parameter int unsigned N_EV = NUM_EV
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] set_vec,
  input  logic            clr_strobe,
  input  logic [N_EV-1:0] clr_mask,
  input  logic [N_EV-1:0] irq_enable,
  input  logic            irq_global_en,
  output logic [N_EV-1:0] events,
  output logic            pending,
  output logic            irq
);
  for (genvar i = 0; i < N_EV; i++) begin : g_ev
    logic ev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        ev_q <= 1'b0;
      else if (set_vec[i])               ev_q <= 1'b1;
      else if (clr_strobe && clr_mask[i]) ev_q <= 1'b0;
    end
    assign events[i] = ev_q;
  end

  assign pending = |(events & irq_enable);
  assign irq     = pending & irq_global_en;
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import audfifo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned AE_LVL = 4,
  parameter int unsigned AF_LVL = 28,
  parameter int unsigned LVL_W  = 6,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              dir_rx,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W:0]   out_data,
  input  logic [LVL_W-1:0]  dma_level,
  input  logic [NUM_EV-1:0] irq_enable,
  input  logic              irq_global_en,
  input  logic              clr_strobe,
  input  logic [NUM_EV-1:0] clr_mask,
  output logic [CNT_W-1:0]  fill_count,
  output logic              flag_empty,
  output logic              flag_aempty,
  output logic              flag_full,
  output logic              flag_aful,
  output logic [NUM_EV-1:0] events,
  output logic              pending,
  output logic              dma_req,
  output logic              irq
);
  level_flags_t      flags;
  logic              push, pop, starve, overflow;
  logic [DATA_W-1:0] head_data;
  logic [NUM_EV-1:0] set_vec;

  assign in_ready  = fifo_en & (~flags.full | out_ready);
  assign out_valid = fifo_en & ~flags.empty;
  assign push      = in_valid & in_ready;
  assign pop       = out_ready & out_valid;
  assign starve    = fifo_en & out_ready & ~out_valid;
  assign overflow  = fifo_en & in_valid & ~in_ready;

  audfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (~fifo_en),
    .push      (push),
    .push_data (in_data),
    .pop       (pop),
    .head_data (head_data),
    .count     (fill_count)
  );

  audfifo_levels #(.DEPTH(DEPTH), .AE_LVL(AE_LVL), .AF_LVL(AF_LVL), .LVL_W(LVL_W)) i_levels (
    .count     (fill_count),
    .enable    (fifo_en),
    .dir_rx    (dir_rx),
    .dma_level (dma_level),
    .flags     (flags),
    .dma_req   (dma_req)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[EV_EMPTY]  = fifo_en & flags.empty;
    set_vec[EV_AEMPTY] = fifo_en & flags.aempty;
    set_vec[EV_FULL]   = fifo_en & flags.full;
    set_vec[EV_AFULL]  = fifo_en & flags.afull;
    set_vec[EV_STARVE] = starve;
    set_vec[EV_OVFL]   = overflow;
  end

  audfifo_events #(.N_EV(NUM_EV)) i_events (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_vec       (set_vec),
    .clr_strobe    (clr_strobe),
    .clr_mask      (clr_mask),
    .irq_enable    (irq_enable),
    .irq_global_en (irq_global_en),
    .events        (events),
    .pending       (pending),
    .irq           (irq)
  );

  assign out_data    = out_valid ? {1'b1, head_data} : '0;
  assign flag_empty  = flags.empty;
  assign flag_aempty = flags.aempty;
  assign flag_full   = flags.full;
  assign flag_aful   = flags.afull;
endmodule

// File: rtl/audfifo_checker.sv
module audfifo_checker #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_ready,
  input logic             out_valid,
  input logic [CNT_W-1:0] fill_count,
  input logic             flag_full,
  input logic [5:0]       events,
  input logic             irq_global_en,
  input logic             irq,
  input logic             dma_req
);
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CNT_W'(DEPTH));

  assert_starve_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && out_ready && !out_valid) |=> events[4]);

  assert_overflow_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && in_valid && !in_ready) |=> events[5]);

  assert_overflow_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && in_valid && !in_ready && !out_ready) |=> $stable(fill_count));

  assert_both_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && in_valid && in_ready && out_ready && out_valid) |=> $stable(fill_count));

  assert_full_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && flag_full && out_ready) |-> in_ready);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_global_en |-> !irq);

  assert_disable_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |=> (fill_count == '0));

  assert_disable_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!dma_req && !in_ready && !out_valid));
endmodule

bind audio_sample_fifo audfifo_checker #(.DEPTH(DEPTH)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_en       (fifo_en),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_ready     (out_ready),
  .out_valid     (out_valid),
  .fill_count    (fill_count),
  .flag_full     (flag_full),
  .events        (events),
  .irq_global_en (irq_global_en),
  .irq           (irq),
  .dma_req       (dma_req)
);

// File: tb/test_audio_sample_fifo.sv
`timescale 1ns/1ps
module test_audio_sample_fifo;
  logic        clk = 1'b0;
  logic        rst_n, fifo_en, dir_rx, in_valid, out_ready;
  logic [15:0] in_data;
  logic        in_ready, out_valid;
  logic [16:0] out_data;
  logic [5:0]  dma_level, irq_enable, clr_mask, fill_count, events;
  logic        irq_global_en, clr_strobe;
  logic        flag_empty, flag_aempty, flag_full, flag_aful, pending, dma_req, irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] mq[$];

  always #2.5 clk = ~clk;

  audio_sample_fifo i_audio_sample_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dir_rx(dir_rx),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .dma_level(dma_level), .irq_enable(irq_enable), .irq_global_en(irq_global_en),
    .clr_strobe(clr_strobe), .clr_mask(clr_mask), .fill_count(fill_count),
    .flag_empty(flag_empty), .flag_aempty(flag_aempty), .flag_full(flag_full),
    .flag_aful(flag_aful), .events(events), .pending(pending),
    .dma_req(dma_req), .irq(irq)
  );

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // All tasks start and end at a falling edge.
  task automatic push_word(logic [15:0] d);
    in_valid = 1'b1; in_data = d;
    if (fifo_en && mq.size() < 32) mq.push_back(d);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_word();
    out_ready = 1'b1;
    if (fifo_en && mq.size() > 0) void'(mq.pop_front());
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic clear_events(logic [5:0] m);
    clr_strobe = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_strobe = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset();
    check("R1", "fill_count", fill_count, 0);
    check("R1", "flag_empty", flag_empty, 1);
    check("R1", "events", events, 0);
    check("R1", "irq", irq, 0);
    check("R1", "out_valid", out_valid, 0);
    check("R1", "out_data", out_data, 0);
  endtask

  task automatic t_disabled_ignore();
    check("R11", "in_ready while disabled", in_ready, 0);
    push_word(16'h1234);
    pop_word();
    @(negedge clk);
    check("R11", "count after disabled strobes", fill_count, 0);
    check("R11", "no events while disabled", events, 0);
    check("R11", "dma_req while disabled", dma_req, 0);
  endtask

  task automatic t_order();
    push_word(16'h1111);
    push_word(16'h2222);
    push_word(16'h3333);
    check("R2", "count after three pushes", fill_count, 3);
    for (int k = 0; k < 3; k++) begin
      check("R2", "head sample with valid flag", out_data, {1'b1, mq[0]});
      pop_word();
    end
    check("R2", "count drained", fill_count, 0);
    check("R2", "out_data when empty", out_data, 0);
  endtask

  task automatic t_starve();
    check("R4", "starve bit clear before", events[4], 0);
    out_ready = 1'b1;
    #1;
    check("R4", "valid flag on empty pop", out_data[16], 0);
    @(negedge clk);
    out_ready = 1'b0;
    check("R4", "starve latched", events[4], 1);
    check("R4", "count unchanged", fill_count, 0);
  endtask

  task automatic t_fill_flags();
    dma_level = 6'd4; dir_rx = 1'b0;
    for (int n = 1; n <= 32; n++) begin
      push_word(16'hA000 + 16'(n - 1));
      check("R2", "count while filling", fill_count, n);
      check("R3", "flag_empty", flag_empty, 0);
      check("R3", "flag_aempty", flag_aempty, int'(n <= 4));
      check("R3", "flag_aful", flag_aful, int'(n >= 28));
      check("R3", "flag_full", flag_full, int'(n == 32));
      check("R6", "tx dma_req", dma_req, int'(n <= 4));
    end
    check("R3", "in_ready when full", in_ready, 0);
    @(negedge clk);
    check("R8", "full event latched", events[2], 1);
    check("R8", "almost-full event latched", events[3], 1);
    check("R8", "empty event sticky", events[0], 1);
  endtask

  task automatic t_overflow();
    push_word(16'hDEAD);
    check("R5", "overflow latched", events[5], 1);
    check("R5", "count unchanged", fill_count, 32);
    check("R5", "head unchanged", out_data, {1'b1, 16'hA000});
  endtask

  task automatic t_both_full();
    clear_events(6'h20);
    check("R10", "overflow cleared", events[5], 0);
    in_valid = 1'b1; in_data = 16'hBEEF; out_ready = 1'b1;
    #1;
    check("R7", "in_ready when full and popping", in_ready, 1);
    void'(mq.pop_front()); mq.push_back(16'hBEEF);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    check("R7", "count held", fill_count, 32);
    check("R7", "no overflow", events[5], 0);
    check("R7", "head advanced", out_data, {1'b1, mq[0]});
    for (int k = 0; k < 31; k++) pop_word();
    check("R7", "passed-through sample at head", out_data, {1'b1, 16'hBEEF});
    check("R2", "one sample left", fill_count, 1);
  endtask

  task automatic t_dma_rx();
    for (int n = 2; n <= 32; n++) push_word(16'h5000 + 16'(n));
    dir_rx = 1'b1; dma_level = 6'd32;
    #1;
    check("R6", "rx dma_req at level", dma_req, 1);
    dma_level = 6'd33;
    #1;
    check("R6", "rx dma_req below level", dma_req, 0);
    dir_rx = 1'b0; dma_level = 6'd4;
    #1;
    check("R6", "tx dma_req above level", dma_req, 0);
    dir_rx = 1'b1; dma_level = 6'd32;
    @(negedge clk);
    pop_word();
    check("R6", "rx dma_req at 31 of 32", dma_req, 0);
  endtask

  task automatic t_irq();
    clear_events(6'h3F);
    check("R10", "set wins for almost-full", events, 6'b001000);
    irq_global_en = 1'b1; irq_enable = 6'b010000;
    #1;
    check("R9", "pending masked", pending, 0);
    check("R9", "irq masked", irq, 0);
    irq_enable = 6'b001000;
    #1;
    check("R9", "pending enabled", pending, 1);
    check("R9", "irq enabled", irq, 1);
    irq_global_en = 1'b0;
    #1;
    check("R9", "irq global gate", irq, 0);
    check("R9", "pending ignores global", pending, 1);
    @(negedge clk);
  endtask

  task automatic t_disable();
    fifo_en = 1'b0;
    mq.delete();
    #1;
    check("R11", "out_valid drops at once", out_valid, 0);
    check("R11", "dma_req drops at once", dma_req, 0);
    @(negedge clk);
    check("R11", "flushed count", fill_count, 0);
    dma_level = 6'd0;
    clear_events(6'h3F);
    check("R10", "all cleared while disabled", events, 0);
    check("R11", "rx level 0 still silent", dma_req, 0);
    fifo_en = 1'b1;
    #1;
    check("R6", "rx level 0 requests when empty", dma_req, 1);
    check("R2", "empty after re-enable", out_data, 0);
    @(negedge clk);
    check("R8", "empty event after re-enable", events[0], 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; dir_rx = 1'b0; in_valid = 1'b0; in_data = '0;
    out_ready = 1'b0; dma_level = 6'd4; irq_enable = '0; irq_global_en = 1'b0;
    clr_strobe = 1'b0; clr_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled_ignore();
    fifo_en = 1'b1;
    @(negedge clk);
    t_order();
    t_starve();
    t_fill_flags();
    t_overflow();
    t_both_full();
    t_dma_rx();
    t_irq();
    t_disable();
    done = 1;
    summary();
    $finish;
  end
endmodule